// File: doc/BRIEF.md
# Double-Buffered 8-bit Compare PWM Channel

This block is one pulse-width channel with its own free-running 8-bit timebase. The timebase advances by one on every clock in which the tick enable is high, and it wraps from 0xFF to 0x00. The output rises at the count that equals the active compare byte and falls when the timebase wraps. The high period is therefore `256 - compare` counts out of 256.

Software sees a 16-bit compare pair. The low byte is the live compare value. The high byte is a shadow that is copied into the live byte at every wrap, so a new duty value written at any time takes effect cleanly from the next period.

Writing the low byte turns comparison off and writing the high byte turns it back on. Comparison left off gives a 0% output that does not glitch. A compare-event flag and a wrap flag are sticky and are cleared by write-one strobes.

Top module: `pwm8_shadow_ch`

## Requirements
- R1: After reset the count, the output, both flags, the compare-enable bit and both compare bytes are 0.
- R2: On each clock with `tick` high the count increases by one and goes from 0xFF to 0x00. With `tick` low the count and the output hold.
- R3: With compare enabled, the output becomes 1 at the edge where the count becomes equal to the compare value in force for that count. At the edge where the count wraps to 0x00, the output becomes 0, unless compare is enabled and the shadow byte is 0x00. For a shadow byte H that was loaded at the previous wrap, the output is 1 exactly for the counts H..0xFF, which is 256-H counts per period. H=0 gives a constant 1.
- R4: At every wrap the live byte is loaded from the shadow byte. A shadow write in the middle of a period changes neither the live byte nor the output of that period.
- R5: A write of the low byte (`wr_lo`) loads the live byte at the next edge, and this takes priority over a reload at the same edge. It also clears the compare-enable bit.
- R6: A write of the high byte (`wr_hi`) loads the shadow byte and sets the compare-enable bit. This holds even when the low byte is written in the same cycle.
- R7: While compare is disabled the output never goes from 0 to 1, which gives a 0% duty.
- R8: When `match_flag_en` is 1, the match flag sets on every compare event. When `match_flag_en` is 0, a compare event leaves the flag unchanged.
- R9: The overflow flag sets on every wrap, which happens once per 256 ticks.
- R10: A `clr_match` or `clr_ovf` pulse clears the matching flag. If a set event falls in the same cycle as the clear, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase advance enable |
| wr_lo | input | 1 | Write strobe for the live compare byte |
| wr_hi | input | 1 | Write strobe for the shadow compare byte |
| wr_data | input | 8 | Write data for both strobes |
| match_flag_en | input | 1 | Lets compare events set the match flag |
| clr_match | input | 1 | Write-one clear of the match flag |
| clr_ovf | input | 1 | Write-one clear of the overflow flag |
| count_o | output | 8 | Timebase count |
| live_o | output | 8 | Live compare byte |
| shadow_o | output | 8 | Shadow compare byte |
| cmp_en_o | output | 1 | Compare-enable bit |
| pwm_o | output | 1 | PWM output |
| match_flag_o | output | 1 | Sticky compare-event flag |
| ovf_flag_o | output | 1 | Sticky wrap flag |

## Verification
Two situations are hard to reach from the ports. Each needs a strobe placed on one exact count. The first is a shadow write landing in the middle of a period. The second is a flag clear that coincides with its own set event.

The bench aligns itself to the count it reads on `count_o` at the falling edge. It then raises the strobe on the chosen count, such as 0xFF for the wrap or the count one below the compare value for the match.

The full duty sweep queues each shadow value at count 0x80 of one period and checks every cycle of the next period against `count >= H`. This covers all 256 values, including the 100% case and the single-count case.

// File: rtl/pwm8_shadow_ch.sv
module pwm8_shadow_ch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  input  logic         match_flag_en,
  input  logic         clr_match,
  input  logic         clr_ovf,
  output logic [W-1:0] count_o,
  output logic [W-1:0] live_o,
  output logic [W-1:0] shadow_o,
  output logic         cmp_en_o,
  output logic         pwm_o,
  output logic         match_flag_o,
  output logic         ovf_flag_o
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt, live, shadow, cnt_nxt, cmp_sel;
  logic         en, pwm, mflag, oflag;
  logic         wrap, hit;

  assign cnt_nxt = cnt + 1'b1;
  assign wrap    = tick && (cnt == TOP);
  assign cmp_sel = wrap ? shadow : live;
  assign hit     = tick && en && (cnt_nxt == cmp_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      pwm <= 1'b0;
    end else if (tick) begin
      cnt <= cnt_nxt;
      if (hit)       pwm <= 1'b1;
      else if (wrap) pwm <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
      en     <= 1'b0;
    end else begin
      if (wr_lo)     live <= wr_data;
      else if (wrap) live <= shadow;
      if (wr_hi)     shadow <= wr_data;
      if (wr_hi)     en <= 1'b1;
      else if (wr_lo) en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mflag <= 1'b0;
      oflag <= 1'b0;
    end else begin
      if (hit && match_flag_en) mflag <= 1'b1;
      else if (clr_match)       mflag <= 1'b0;
      if (wrap)                 oflag <= 1'b1;
      else if (clr_ovf)         oflag <= 1'b0;
    end
  end

  assign count_o      = cnt;
  assign live_o       = live;
  assign shadow_o     = shadow;
  assign cmp_en_o     = en;
  assign pwm_o        = pwm;
  assign match_flag_o = mflag;
  assign ovf_flag_o   = oflag;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count_o == $past(count_o) + 1'b1);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_o) && $stable(pwm_o));
  p_wrap_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_o == TOP && shadow_o != '0) |=> !pwm_o);
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_o == TOP && !wr_lo) |=> live_o == $past(shadow_o));
  p_lo_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wr_hi) |=> !cmp_en_o && live_o == $past(wr_data));
  p_hi_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> cmp_en_o && shadow_o == $past(wr_data));
  p_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_en_o && !pwm_o) |=> !pwm_o);
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_o == TOP) |=> ovf_flag_o);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !clr_ovf) |=> ovf_flag_o);
endmodule

// File: tb/pwm8_shadow_ch_bench.sv
module pwm8_shadow_ch_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic wr_lo = 1'b0, wr_hi = 1'b0, mfe = 1'b0, clr_m = 1'b0, clr_o = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt, live, shadow;
  logic en, pwm, mflag, oflag;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm8_shadow_ch u_pwm8_shadow_ch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wr_data(wr_data), .match_flag_en(mfe), .clr_match(clr_m), .clr_ovf(clr_o),
    .count_o(cnt), .live_o(live), .shadow_o(shadow), .cmp_en_o(en),
    .pwm_o(pwm), .match_flag_o(mflag), .ovf_flag_o(oflag));

  localparam int NT = 6;
  localparam logic [7:0] TAB_H   [NT] = '{8'h00, 8'h01, 8'h40, 8'h80, 8'hFE, 8'hFF};
  localparam int         TAB_CNT [NT] = '{256, 255, 192, 128, 2, 1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    while (cnt != v) @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0; clr_m = 1'b0; clr_o = 1'b0;
  endtask

  task automatic write_hi(input logic [7:0] d);
    wr_hi = 1'b1; wr_data = d; step();
  endtask

  task automatic high_count(output int n);
    n = 0;
    for (int i = 0; i < 256; i++) begin
      n += int'(pwm);
      step();
    end
  endtask

  initial begin
    int n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cnt == 0 && pwm == 0 && mflag == 0 && oflag == 0 && en == 0 &&
        live == 0 && shadow == 0, "R1 reset state", {cnt, live, shadow}, 0);

    // R2 hold with tick low, then advance
    repeat (5) step();
    chk(cnt == 0, "R2 hold without tick", cnt, 0);
    tick = 1'b1;
    step(); step();
    chk(cnt == 2, "R2 count advance", cnt, 2);

    // R7 disabled compare gives 0% output
    wait_cnt(8'h00);
    high_count(n);
    chk(n == 0, "R7 zero duty while disabled", n, 0);

    // duty table
    for (int k = 0; k < NT; k++) begin
      wait_cnt(8'h80);
      write_hi(TAB_H[k]);
      wait_cnt(8'h00);
      high_count(n);
      chk(n == TAB_CNT[k], "R3 duty table", n, TAB_CNT[k]);
    end

    // full sweep against reference: out = (count >= H)
    wait_cnt(8'h00);
    for (int p = 0; p <= 256; p++) begin
      bad = 0;
      for (int i = 0; i < 256; i++) begin
        if (p > 0 && pwm != (i >= p - 1)) bad++;
        if (i == 128 && p < 256) begin wr_hi = 1'b1; wr_data = 8'(p); end
        step();
      end
      if (p > 0) chk(bad == 0, "R3 sweep mismatches", bad, 0);
    end

    // R4 mid-period shadow write does not touch live byte
    wait_cnt(8'h10);
    write_hi(8'h90);
    chk(live == 8'hFF && shadow == 8'h90, "R4 live held mid-period", live, 8'hFF);
    wait_cnt(8'h00);
    chk(live == 8'h90, "R4 reload at wrap", live, 8'h90);

    // R2 hold of output with tick low mid-high
    wait_cnt(8'hA0);
    tick = 1'b0;
    repeat (4) step();
    chk(cnt == 8'hA0 && pwm == 1'b1, "R2 hold count and output", {cnt, pwm}, {8'hA0, 1'b1});
    tick = 1'b1;

    // R5 low-byte write: live loads, compare disabled, wins over reload
    wait_cnt(8'hFF);
    wr_lo = 1'b1; wr_data = 8'h20; step();
    chk(live == 8'h20, "R5 low write beats reload", live, 8'h20);
    chk(en == 1'b0, "R5 low write clears enable", en, 0);
    high_count(n);
    chk(n == 0, "R7 no output after low write", n, 0);

    // R6 both strobes together: enable ends set
    wr_lo = 1'b1; wr_hi = 1'b1; wr_data = 8'h40; step();
    chk(en == 1'b1 && shadow == 8'h40 && live == 8'h40, "R6 both writes", en, 1);

    // R8 flag gated by enable input
    clr_m = 1'b1; step();
    mfe = 1'b0;
    wait_cnt(8'h00); high_count(n);
    chk(mflag == 1'b0, "R8 no flag when disabled", mflag, 0);
    mfe = 1'b1;
    wait_cnt(8'h41);
    chk(mflag == 1'b1, "R8 flag on compare event", mflag, 1);

    // R10 clear collides with match set
    clr_m = 1'b1; step();
    chk(mflag == 1'b0, "R10 match clear", mflag, 0);
    wait_cnt(8'h3F);
    clr_m = 1'b1; step();
    chk(mflag == 1'b1, "R10 set beats clear (match)", mflag, 1);

    // R9 overflow flag and R10 collision
    clr_o = 1'b1; step();
    chk(oflag == 1'b0, "R10 ovf clear", oflag, 0);
    wait_cnt(8'h00);
    chk(oflag == 1'b1, "R9 ovf on wrap", oflag, 1);
    clr_o = 1'b1; step();
    wait_cnt(8'hFF);
    clr_o = 1'b1; step();
    chk(oflag == 1'b1, "R10 set beats clear (ovf)", oflag, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule